// File: doc/BRIEF.md
# ADC Autoconversion Sequencer Controller

This block steps an analog-to-digital converter through a programmed list of input channels. It runs either as two independent sequencers or as one cascaded sequencer. In the independent arrangement, sequencer A has a 4-bit slot pointer and sequencer B has a 3-bit slot pointer. In the cascaded arrangement, sequencer A alone walks up to 16 slots. A start trigger loads a single shared 4-bit countdown counter from a programmed maximum-conversions value. Each accepted conversion-done pulse then moves the active sequencer's pointer forward and decrements the counter. When simultaneous sampling is selected, one step takes two done pulses, because each step stands for a pair of conversions.

The channel number for the current slot is read from a 16-entry programmable slot table. Sequencer A reads entries 0 to 15 through its pointer. Sequencer B reads entries 8 to 15 at 8 plus its pointer. A read-only 16-bit status word reports the counter and both pointers at every cycle. The counter value, read together with the busy flags, gives the exact number of conversions left: a value of N with N from 1 to 15 means N+1 remain, and 0 means one remains while busy and none remain while idle. The converter itself is outside the block and is represented only by the done pulse.

Top module: `adc_seq_ctrl`

## Requirements
- R1: With both sequencers idle, a high `start_a` sets `busy_a`, loads the counter (status bits 11:8) with `max_a`, and clears pointer A (status bits 3:0) at the next clock edge. `start_a` wins when both starts are high.
- R2: While a sequencer is busy, `simul_mode` is low and the counter is nonzero, each `conv_done` pulse decrements the counter by one and advances that sequencer's pointer by one.
- R3: While `simul_mode` is high, only every second `conv_done` pulse of a sequence steps the counter and pointer. The first pulse of each pair leaves both unchanged.
- R4: The step taken at counter value 0 ends the sequence. The busy flag clears, that sequencer's pointer returns to 0, and its end-of-sequence output (`eos_a` or `eos_b`) is high for exactly one cycle.
- R5: A start trigger that arrives while either sequencer is busy is ignored. The counter, the pointers and the busy flags are left unchanged.
- R6: With both sequencers idle and `start_a` low, `start_b` in independent mode (`cascade` low) starts sequencer B. The counter is loaded with `max_b` clamped to at most 7, and pointer B (status bits 6:4) is cleared.
- R7: While `cascade` is high, `start_b` is ignored and `busy_b` stays low.
- R8: `chsel` equals slot-table entry 8+pointer B while sequencer B is busy, and equals entry pointer A at all other times. Table entry `tbl_addr` takes `tbl_data` at a clock edge where `tbl_we` is high.
- R9: Status bits 15:12 and bit 7 always read zero. After reset, the status word, the busy flags, the end-of-sequence outputs and every table entry are zero.
- R10: A `conv_done` pulse while both sequencers are idle has no effect on the status word or on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cascade | input | 1 | 1 = single 16-slot sequencer, 0 = two sequencers |
| simul_mode | input | 1 | 1 = one step per pair of done pulses |
| max_a | input | 4 | Maximum-conversions value for sequencer A |
| max_b | input | 4 | Maximum-conversions value for sequencer B, clamped to 7 |
| start_a | input | 1 | Start trigger, sequencer A |
| start_b | input | 1 | Start trigger, sequencer B |
| conv_done | input | 1 | One-cycle conversion-complete pulse |
| tbl_we | input | 1 | Slot table write enable |
| tbl_addr | input | 4 | Slot table write index |
| tbl_data | input | CH_W | Channel number to write |
| chsel | output | CH_W | Channel select for the current slot |
| busy_a | output | 1 | Sequencer A running |
| busy_b | output | 1 | Sequencer B running |
| eos_a | output | 1 | End-of-sequence pulse, sequencer A |
| eos_b | output | 1 | End-of-sequence pulse, sequencer B |
| status | output | 16 | {0000, counter, 0, pointer B, pointer A} |

## Verification
The bench builds the block with its default channel width of 4. At that width, every `max_a` value from 0 to 15 can be swept in both the single-step mode and the paired mode, and every `max_b` value from 0 to 15 can be swept through the clamp. The slot table is loaded with an arithmetic pattern, so each step's `chsel` can be predicted from the pointer alone. Around these sweeps, the bench sends starts while a sequence is running, `start_b` with `cascade` high, and done pulses while the block is idle.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int CH_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cascade,
  input  logic            simul_mode,
  input  logic [3:0]      max_a,
  input  logic [3:0]      max_b,
  input  logic            start_a,
  input  logic            start_b,
  input  logic            conv_done,
  input  logic            tbl_we,
  input  logic [3:0]      tbl_addr,
  input  logic [CH_W-1:0] tbl_data,
  output logic [CH_W-1:0] chsel,
  output logic            busy_a,
  output logic            busy_b,
  output logic            eos_a,
  output logic            eos_b,
  output logic [15:0]     status
);
  localparam int SLOTS   = 16;
  localparam int PA_W    = $clog2(SLOTS);
  localparam int PB_W    = PA_W - 1;
  localparam int B_LIMIT = (1 << PB_W) - 1;

  logic [3:0]      cnt;
  logic [PA_W-1:0] ptr_a;
  logic [PB_W-1:0] ptr_b;
  logic            half;
  logic [CH_W-1:0] tbl [SLOTS];

  wire       idle   = !busy_a && !busy_b;
  wire       go_a   = idle && start_a;
  wire       go_b   = idle && !start_a && start_b && !cascade;
  wire       take   = conv_done && !idle;
  wire       step   = take && (!simul_mode || half);
  wire [3:0] max_bc = (max_b > 4'(B_LIMIT)) ? 4'(B_LIMIT) : max_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      ptr_a  <= '0;
      ptr_b  <= '0;
      half   <= 1'b0;
      busy_a <= 1'b0;
      busy_b <= 1'b0;
      eos_a  <= 1'b0;
      eos_b  <= 1'b0;
    end else begin
      eos_a <= 1'b0;
      eos_b <= 1'b0;
      if (go_a) begin
        busy_a <= 1'b1;
        cnt    <= max_a;
        ptr_a  <= '0;
        half   <= 1'b0;
      end else if (go_b) begin
        busy_b <= 1'b1;
        cnt    <= max_bc;
        ptr_b  <= '0;
        half   <= 1'b0;
      end else if (take) begin
        half <= simul_mode ? ~half : 1'b0;
        if (step) begin
          if (cnt == '0) begin
            busy_a <= 1'b0;
            busy_b <= 1'b0;
            eos_a  <= busy_a;
            eos_b  <= busy_b;
            ptr_a  <= '0;
            ptr_b  <= '0;
          end else begin
            cnt <= cnt - 4'd1;
            if (busy_a) ptr_a <= ptr_a + 1'b1;
            else        ptr_b <= ptr_b + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) tbl[i] <= '0;
    end else if (tbl_we) begin
      tbl[tbl_addr] <= tbl_data;
    end
  end

  assign chsel  = busy_b ? tbl[{1'b1, ptr_b}] : tbl[ptr_a];
  assign status = {4'b0000, cnt, 1'b0, ptr_b, ptr_a};
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cascade,
  input logic        simul_mode,
  input logic [3:0]  max_a,
  input logic [3:0]  max_b,
  input logic        start_a,
  input logic        start_b,
  input logic        conv_done,
  input logic        busy_a,
  input logic        busy_b,
  input logic        eos_a,
  input logic        eos_b,
  input logic [15:0] status
);
  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_a && !busy_b && start_a) |=> (busy_a && status[11:8] == $past(max_a) && status[3:0] == 4'd0)); // R1
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_a && conv_done && !simul_mode && status[11:8] != 4'd0)
    |=> (status[11:8] == $past(status[11:8]) - 4'd1 && status[3:0] == $past(status[3:0]) + 4'd1)); // R2
  AST_EOS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    eos_a |=> !eos_a); // R4
  AST_EOS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (eos_a || eos_b) |-> (!busy_a && !busy_b && status[6:0] == 7'd0)); // R4
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_a && !conv_done) |=> (busy_a && $stable(status))); // R5
  AST_B_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_a && !busy_b && !start_a && start_b && !cascade) |=> (busy_b && status[11:8] <= 4'd7)); // R6
  AST_CASC_NO_B: assert property (@(posedge clk) disable iff (!rst_n)
    (cascade && !busy_b) |=> !busy_b); // R7
  AST_BUSY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_a && busy_b)); // R5
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (status[15:12] == 4'd0 && status[7] == 1'b0)); // R9
  AST_IDLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_a && !busy_b && !start_a && !start_b && conv_done) |=> ($stable(status) && !busy_a && !busy_b)); // R10
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cascade(cascade), .simul_mode(simul_mode),
  .max_a(max_a), .max_b(max_b), .start_a(start_a), .start_b(start_b),
  .conv_done(conv_done), .busy_a(busy_a), .busy_b(busy_b),
  .eos_a(eos_a), .eos_b(eos_b), .status(status)
);

// File: tb/tb_adc_seq_ctrl.sv
`timescale 1ns/1ps
module tb_adc_seq_ctrl;
  logic clk = 0, rst_n = 0;
  logic cascade = 0, simul_mode = 0, start_a = 0, start_b = 0, conv_done = 0, tbl_we = 0;
  logic [3:0] max_a = 0, max_b = 0, tbl_addr = 0, tbl_data = 0;
  logic [3:0] chsel;
  logic busy_a, busy_b, eos_a, eos_b;
  logic [15:0] status;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  adc_seq_ctrl dut (.clk(clk), .rst_n(rst_n), .cascade(cascade), .simul_mode(simul_mode),
    .max_a(max_a), .max_b(max_b), .start_a(start_a), .start_b(start_b), .conv_done(conv_done),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data), .chsel(chsel),
    .busy_a(busy_a), .busy_b(busy_b), .eos_a(eos_a), .eos_b(eos_b), .status(status));

  function automatic logic [3:0] tv(int i);
    return 4'((i * 7 + 3) % 16);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic done_pulse;
    conv_done = 1; tick; conv_done = 0;
  endtask

  task automatic run_a(int m, bit sim);
    simul_mode = sim; max_a = 4'(m); start_a = 1; tick; start_a = 0;
    chk(busy_a && status[11:8] == 4'(m), "R1 load", int'(status[11:8]), m);
    chk(status[3:0] == 0 && chsel == tv(0), "R8 chsel slot0", int'(chsel), int'(tv(0)));
    for (int k = 0; k <= m; k++) begin
      if (sim) begin
        done_pulse;
        chk(status[11:8] == 4'(m - k) && status[3:0] == 4'(k), "R3 first of pair", int'(status[11:8]), m - k);
      end
      done_pulse;
      if (k == m) begin
        chk(!busy_a && eos_a && status[3:0] == 0, "R4 end", int'(busy_a), 0);
      end else begin
        chk(status[11:8] == 4'(m - k - 1), sim ? "R3 pair step" : "R2 step", int'(status[11:8]), m - k - 1);
        chk(status[3:0] == 4'(k + 1) && chsel == tv(k + 1), "R8 chsel A", int'(chsel), int'(tv(k + 1)));
      end
    end
    tick;
    chk(!eos_a, "R4 eos one cycle", int'(eos_a), 0);
  endtask

  task automatic run_b(int m);
    int e;
    e = (m > 7) ? 7 : m;
    simul_mode = 0; max_b = 4'(m); start_b = 1; tick; start_b = 0;
    chk(busy_b && status[11:8] == 4'(e) && status[6:4] == 0, "R6 clamp load", int'(status[11:8]), e);
    for (int k = 0; k <= e; k++) begin
      chk(chsel == tv(8 + k) && status[6:4] == 3'(k), "R8 chsel B", int'(chsel), int'(tv(8 + k)));
      done_pulse;
    end
    chk(!busy_b && eos_b && status[6:4] == 0, "R4 end B", int'(busy_b), 0);
    tick;
    chk(!eos_b, "R4 eos B one cycle", int'(eos_b), 0);
  endtask

  initial begin
    #(200000 * 20);
    bad++; total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick; tick;
    chk(status == 0 && !busy_a && !busy_b && !eos_a && !eos_b && chsel == 0, "R9 reset", int'(status), 0);
    rst_n = 1; tick;
    for (int i = 0; i < 16; i++) begin
      tbl_we = 1; tbl_addr = 4'(i); tbl_data = tv(i); tick;
    end
    tbl_we = 0; tick;
    chk(chsel == tv(0), "R8 table write", int'(chsel), int'(tv(0)));
    for (int m = 0; m < 16; m++) begin
      run_a(m, 0);
      run_a(m, 1);
    end
    for (int m = 0; m < 16; m++) run_b(m);
    // R5: starts while busy
    max_a = 9; start_a = 1; tick; start_a = 0; done_pulse;
    max_a = 2; max_b = 1; start_a = 1; start_b = 1; tick; start_a = 0; start_b = 0;
    chk(busy_a && !busy_b && status[11:8] == 8 && status[3:0] == 1, "R5 start ignored", int'(status[11:8]), 8);
    for (int k = 0; k < 9; k++) done_pulse;
    chk(!busy_a && status[11:8] == 0, "R5 sequence finished", int'(busy_a), 0);
    tick;
    // R7: start_b ignored in cascade
    cascade = 1; max_b = 5; start_b = 1; tick; start_b = 0;
    chk(!busy_b && status == 0, "R7 cascade start_b", int'(busy_b), 0);
    cascade = 0;
    // R10: done while idle
    done_pulse; done_pulse;
    chk(status == 0 && !busy_a && !busy_b && !eos_a && !eos_b, "R10 idle done", int'(status), 0);
    chk(status[15:12] == 0 && status[7] == 0, "R9 reserved", int'(status), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule